// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and main memory. It takes each processor store and keeps it until memory has accepted it, so the processor can continue at once. The buffer has four slots. Each slot holds one block-aligned address and up to four words of that block, and each word has its own valid bit. A store to a block that already has an open slot joins that slot and does not use a new one. This cuts the number of memory transactions when stores fall close together in the same block.

Slots go to memory oldest first, over a request/acknowledge handshake that carries a whole block and its word mask. The oldest slot is the one being offered to memory. That slot is locked, and a store that hits its block opens a fresh slot. When the buffer cannot take a store, it raises a stall so that the cache can hold the processor. An empty flag lets a later read miss wait until all earlier writes have left the buffer.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `bufEmpty` is 1, and `memReq` and `stStall` are 0.
- R2: An accepted store that matches no open slot takes a new slot at the back of the queue. The slot's block address is `stAddr[29:2]`, and its mask has only bit `stAddr[1:0]` set. That word holds `stData` at `memData[32*k +: 32]`, where k = `stAddr[1:0]`. The other words of the slot read as zero.
- R3: An accepted store whose block matches an open (not oldest) slot merges into that slot. It sets mask bit `stAddr[1:0]` and overwrites that word. It takes no new slot.
- R4: `memReq` is 1 whenever a slot is occupied. `memBlkAddr`, `memData` and `memMask` show the oldest slot. That slot is removed at the clock edge on which `memReq` and `memAck` are both 1, and slots leave in the order they were created.
- R5: The oldest slot is locked. A store to its block opens a new slot and never changes what is being offered to memory.
- R6: `stStall` is 1 only when `stValid` is 1, all four slots are occupied, and no open slot matches the block. A stalled store changes nothing. A merging store is accepted even when the buffer is full.
- R7: When a store and a completed drain happen in the same cycle, both take effect. A slot freed by that drain can be used from the next cycle on, so a full buffer still stalls a non-matching store in the cycle of the drain.
- R8: `bufEmpty` is 1 exactly when no slot is occupied, and it rises the cycle after the last slot drains.
- R9: While `memReq` is 1 and `memAck` is 0, `memBlkAddr`, `memData` and `memMask` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request from the cache |
| stAddr | input | 30 | Word address of the store (block in bits 29:2, word in 1:0) |
| stData | input | 32 | Store data |
| stStall | output | 1 | Store cannot be accepted this cycle |
| memReq | output | 1 | Oldest slot offered to memory |
| memAck | input | 1 | Memory accepts the offered slot |
| memBlkAddr | output | 28 | Block address of the offered slot |
| memData | output | 128 | Four words of the offered slot, word k at bits 32k+31:32k |
| memMask | output | 4 | Valid word mask of the offered slot |
| bufEmpty | output | 1 | No slot occupied |

## Verification
A corrupted pointer or a stale valid bit shows up at the memory port one cycle after the store that exposed it. The wrong block, mask or word order appears on `memBlkAddr`/`memMask`/`memData`, or `memReq` and `bufEmpty` disagree with the number of occupied slots. A wrong match result or a wrong lock on the oldest slot shows up as an extra slot or a missing merge. This is visible as soon as that slot reaches the head of the queue. The same fault can also raise `stStall` in the very cycle of the store. The reference model is compared against all outputs on every clock, so a divergence is caught within a few cycles of its cause.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  parameter int unsigned WB_ENTRIES = 4;
  parameter int unsigned WB_WORDS   = 4;
  parameter int unsigned WB_DATA_W  = 32;
  parameter int unsigned WB_WADDR_W = 30;

  localparam int unsigned OFF_W = $clog2(WB_WORDS);
  localparam int unsigned BLK_W = WB_WADDR_W - OFF_W;
  localparam int unsigned IDX_W = $clog2(WB_ENTRIES);
  localparam int unsigned CNT_W = $clog2(WB_ENTRIES + 1);
  localparam int unsigned LINE_W = WB_WORDS * WB_DATA_W;

  typedef struct packed {
    logic             wrEn;
    logic             newEntry;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } wbStrobe_t;
endpackage

// File: rtl/wbuf_datapath.sv
module wbuf_datapath
  import wbuf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WB_WADDR_W-1:0] stAddr,
  input  logic [WB_DATA_W-1:0]  stData,
  input  logic [WB_ENTRIES-1:0] openVec,
  input  wbStrobe_t             strobe,
  output logic [WB_ENTRIES-1:0] matchVec,
  output logic [BLK_W-1:0]      memBlkAddr,
  output logic [LINE_W-1:0]     memData,
  output logic [WB_WORDS-1:0]   memMask
);
  logic [BLK_W-1:0]                    blkQ  [WB_ENTRIES];
  logic [WB_WORDS-1:0][WB_DATA_W-1:0]  dataQ [WB_ENTRIES];
  logic [WB_WORDS-1:0]                 maskQ [WB_ENTRIES];

  logic [BLK_W-1:0]    stBlk;
  logic [OFF_W-1:0]    stOff;
  logic [WB_WORDS-1:0] offHot;

  assign stBlk  = stAddr[WB_WADDR_W-1:OFF_W];
  assign stOff  = stAddr[OFF_W-1:0];
  assign offHot = WB_WORDS'(1) << stOff;

  for (genvar e = 0; e < WB_ENTRIES; e++) begin : gEntry
    logic selHere;
    assign selHere     = strobe.wrEn && (strobe.wrIdx == IDX_W'(e));
    assign matchVec[e] = openVec[e] && (blkQ[e] == stBlk);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        blkQ[e]  <= '0;
        maskQ[e] <= '0;
        dataQ[e] <= '0;
      end else if (selHere) begin
        if (strobe.newEntry) begin
          blkQ[e]  <= stBlk;
          maskQ[e] <= offHot;
          for (int w = 0; w < WB_WORDS; w++)
            dataQ[e][w] <= offHot[w] ? stData : '0;
        end else begin
          maskQ[e]        <= maskQ[e] | offHot;
          dataQ[e][stOff] <= stData;
        end
      end
    end
  end

  assign memBlkAddr = blkQ[strobe.rdIdx];
  assign memData    = dataQ[strobe.rdIdx];
  assign memMask    = maskQ[strobe.rdIdx];
endmodule

// File: rtl/wbuf_control.sv
module wbuf_control
  import wbuf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stValid,
  input  logic [WB_ENTRIES-1:0] matchVec,
  input  logic                  memAck,
  output wbStrobe_t             strobe,
  output logic [WB_ENTRIES-1:0] openVec,
  output logic                  stStall,
  output logic                  memReq,
  output logic                  bufEmpty
);
  logic [WB_ENTRIES-1:0] validQ;
  logic [IDX_W-1:0]      headQ, tailQ;
  logic [CNT_W-1:0]      countQ;

  logic             anyMatch, isFull, accept, alloc, pop;
  logic [IDX_W-1:0] matchIdx;

  function automatic logic [IDX_W-1:0] nextPtr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(WB_ENTRIES - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < WB_ENTRIES; i++)
      if (matchVec[i]) matchIdx = IDX_W'(i);
  end

  assign anyMatch = |matchVec;
  assign isFull   = (countQ == CNT_W'(WB_ENTRIES));
  assign stStall  = stValid && !anyMatch && isFull;
  assign accept   = stValid && !stStall;
  assign alloc    = accept && !anyMatch;
  assign memReq   = validQ[headQ];
  assign pop      = memReq && memAck;
  assign bufEmpty = (countQ == '0);

  always_comb begin
    openVec        = validQ;
    openVec[headQ] = 1'b0;
  end

  always_comb begin
    strobe.wrEn     = accept;
    strobe.newEntry = alloc;
    strobe.wrIdx    = anyMatch ? matchIdx : tailQ;
    strobe.rdIdx    = headQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (alloc) begin
        validQ[tailQ] <= 1'b1;
        tailQ         <= nextPtr(tailQ);
      end
      if (pop) begin
        validQ[headQ] <= 1'b0;
        headQ         <= nextPtr(headQ);
      end
      case ({alloc, pop})
        2'b10:   countQ <= countQ + CNT_W'(1);
        2'b01:   countQ <= countQ - CNT_W'(1);
        default: countQ <= countQ;
      endcase
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import wbuf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stValid,
  input  logic [WB_WADDR_W-1:0] stAddr,
  input  logic [WB_DATA_W-1:0]  stData,
  output logic                  stStall,
  output logic                  memReq,
  input  logic                  memAck,
  output logic [BLK_W-1:0]      memBlkAddr,
  output logic [LINE_W-1:0]     memData,
  output logic [WB_WORDS-1:0]   memMask,
  output logic                  bufEmpty
);
  wbStrobe_t             strobe;
  logic [WB_ENTRIES-1:0] openVec;
  logic [WB_ENTRIES-1:0] matchVec;

  wbuf_control uCtrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .matchVec(matchVec),
    .memAck(memAck), .strobe(strobe), .openVec(openVec),
    .stStall(stStall), .memReq(memReq), .bufEmpty(bufEmpty)
  );

  wbuf_datapath uData (
    .clk(clk), .rstN(rstN), .stAddr(stAddr), .stData(stData),
    .openVec(openVec), .strobe(strobe), .matchVec(matchVec),
    .memBlkAddr(memBlkAddr), .memData(memData), .memMask(memMask)
  );
endmodule

// File: rtl/merge_wbuf_checker.sv
module merge_wbuf_checker
  import wbuf_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                stValid,
  input logic                stStall,
  input logic                memReq,
  input logic                memAck,
  input logic [BLK_W-1:0]    memBlkAddr,
  input logic [LINE_W-1:0]   memData,
  input logic [WB_WORDS-1:0] memMask,
  input logic                bufEmpty
);
  a_r8_empty_vs_req: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty == !memReq);

  a_r6_stall_needs_store: assert property (@(posedge clk) disable iff (!rstN)
    stStall |-> stValid);

  a_r6_stall_needs_occupancy: assert property (@(posedge clk) disable iff (!rstN)
    stStall |-> (memReq && !bufEmpty));

  a_r2_store_fills_empty: assert property (@(posedge clk) disable iff (!rstN)
    (bufEmpty && stValid) |=> !bufEmpty);

  a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memBlkAddr) && $stable(memMask) && $stable(memData)));

  a_r4_offer_has_word: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memMask != '0));
endmodule

bind merge_wbuf merge_wbuf_checker uChk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stStall(stStall),
  .memReq(memReq), .memAck(memAck), .memBlkAddr(memBlkAddr),
  .memData(memData), .memMask(memMask), .bufEmpty(bufEmpty)
);

// File: tb/merge_wbuf_test.sv
module merge_wbuf_test;
  import wbuf_pkg::*;

  localparam time CLK_PER = 20ns;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  stValid = 1'b0;
  logic [WB_WADDR_W-1:0] stAddr = '0;
  logic [WB_DATA_W-1:0]  stData = '0;
  logic                  stStall;
  logic                  memReq;
  logic                  memAck = 1'b0;
  logic [BLK_W-1:0]      memBlkAddr;
  logic [LINE_W-1:0]     memData;
  logic [WB_WORDS-1:0]   memMask;
  logic                  bufEmpty;

  always #(CLK_PER/2) clk = ~clk;

  merge_wbuf uut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .stStall(stStall), .memReq(memReq), .memAck(memAck), .memBlkAddr(memBlkAddr),
    .memData(memData), .memMask(memMask), .bufEmpty(bufEmpty)
  );

  typedef struct {
    logic [BLK_W-1:0]  blk;
    logic [LINE_W-1:0] dat;
    logic [WB_WORDS-1:0] msk;
  } ent_t;

  ent_t mq[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  task automatic chk(input string tag, input string what, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare against model, then advance model
  task automatic cyc(input string tag, input bit v, input logic [BLK_W-1:0] blk,
                     input logic [OFF_W-1:0] off, input bit ack);
    logic [WB_DATA_W-1:0] d;
    int  hit;
    bit  expStall;
    bit  expReq;
    d = $urandom;
    @(negedge clk);
    stValid = v; stAddr = {blk, off}; stData = d; memAck = ack;
    #2;
    expReq = (mq.size() != 0);
    hit = -1;
    for (int i = 1; i < mq.size(); i++) if (mq[i].blk == blk) hit = i;
    expStall = v && (hit < 0) && (mq.size() == WB_ENTRIES);
    chk(tag, "memReq", LINE_W'(memReq), LINE_W'(expReq));
    chk(tag, "bufEmpty", LINE_W'(bufEmpty), LINE_W'(!expReq));
    chk(tag, "stStall", LINE_W'(stStall), LINE_W'(expStall));
    if (expReq) begin
      chk(tag, "memBlkAddr", LINE_W'(memBlkAddr), LINE_W'(mq[0].blk));
      chk(tag, "memMask", LINE_W'(memMask), LINE_W'(mq[0].msk));
      chk(tag, "memData", memData, mq[0].dat);
    end
    if (v && !expStall) begin
      if (hit >= 0) begin
        mq[hit].msk[off] = 1'b1;
        mq[hit].dat[32*off +: 32] = d;
      end else begin
        ent_t n;
        n.blk = blk; n.msk = '0; n.msk[off] = 1'b1;
        n.dat = '0; n.dat[32*off +: 32] = d;
        mq.push_back(n);
      end
    end
    if (expReq && ack) void'(mq.pop_front());
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc("R1", 0, '0, 0, 0);                 // reset state
    cyc("R2", 1, 28'h10, 2, 0);             // new slot, block 10
    cyc("R2", 1, 28'h20, 0, 0);             // new slot, block 20
    cyc("R3", 1, 28'h20, 1, 0);             // merge
    cyc("R3", 1, 28'h20, 3, 0);             // merge
    cyc("R3", 1, 28'h20, 1, 0);             // overwrite word 1
    cyc("R5", 1, 28'h10, 0, 0);             // head locked: new slot
    cyc("R9", 0, '0, 0, 0);                 // hold offer
    cyc("R6", 1, 28'h30, 2, 0);             // fourth slot, now full
    cyc("R6", 1, 28'h40, 1, 0);             // stall
    cyc("R6", 1, 28'h40, 1, 0);             // still stalled, no effect
    cyc("R6", 1, 28'h20, 2, 0);             // merge while full accepted
    cyc("R6", 1, 28'h10, 3, 0);             // merge into younger block-10 slot
    cyc("R7", 1, 28'h40, 1, 1);             // drain + store: still stalls
    cyc("R7", 1, 28'h40, 1, 0);             // freed slot used
    cyc("R7", 1, 28'h50, 0, 1);             // full again: stall with drain
    cyc("R7", 1, 28'h30, 3, 1);             // drain with merge
    for (int k = 0; k < 8; k++) cyc("R4", 0, '0, 0, 1);   // drain in order
    cyc("R8", 0, '0, 0, 0);                 // empty
    cyc("R2", 1, 28'h60, 3, 1);             // store into empty with ack
    cyc("R8", 0, '0, 0, 1);
    cyc("R8", 0, '0, 0, 0);
    for (int k = 0; k < 3000; k++)
      cyc("R4", ($urandom % 4) != 0, BLK_W'($urandom % 6), OFF_W'($urandom),
          ($urandom % 3) == 0);
    for (int k = 0; k < 10; k++) cyc("R8", 0, '0, 0, 1);
    cyc("R8", 0, '0, 0, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule